// File: doc/BRIEF.md
# Trap Vector Dispatch Unit

This block turns a fault request from the pipeline into a redirect to the privileged handler. Each request bit stands for one fault class. When one or more bits are raised, the block picks the winner by fixed priority and forms the handler entry address from a programmable base plus a fixed per-class offset. It produces the address that follows the entry address, and it decides whether and what to write into the exception-return register. All of these appear together with a one-cycle redirect strobe in the cycle after the request.

Software sets a restart flag and a skip (trap) flag for each class. The restart flag forces the return address to be saved even when the current PC is not word aligned. The skip flag saves the address one instruction past the faulting one. Each class also has a small saturating event counter, which a select input reads out.

Top module: `trap_dispatch`

## Requirements
- R1: After synchronous reset, `redirect` and `exc_we` are 0 and every event counter reads 0.
- R2: The entry offset per class index is: 0 reset 0x0001, 1 machine check 0x0401, 2 instruction access violation 0x0081, 3 instruction miss 0x0181, 4 illegal opcode 0x0481, 5 float disabled 0x0581, 6 privileged call 0x2001, 7 arithmetic 0x0501, 8 integer overflow 0x0501, 9 unaligned 0x0301, 10 data miss single 0x0201, 11 data miss double 0x0281, 12 data page fault 0x0381, 13 data access violation 0x0381, 14 interrupt 0x0101. `new_pc` equals the base with bit 0 cleared, plus that offset.
- R3: When several request bits are set in one cycle, the lowest index wins. Reset (index 0) wins over all others.
- R4: `next_pc` equals `new_pc` plus 4.
- R5: `exc_we` is 1 with the redirect only when the winner's `restart_mask` bit is set or `cur_pc[1:0]` is 00. Otherwise it is 0.
- R6: When written, `exc_addr` is `cur_pc`, plus 4 if the winner's `skip_mask` bit is set.
- R7: `redirect` is high for exactly one cycle, in the cycle after an accepted request. A request present while `redirect` is high is ignored.
- R8: `new_pc[0]` equals bit 0 of the offset, which is 1 for every class, whatever `handler_base[0]` is.
- R9: Each accepted request increments the winner's counter, which saturates at all ones. `cnt_value` shows the counter chosen by `cnt_sel`. A select of 15 or above reads 0.
- R10: Classes that share an offset (7 and 8, 12 and 13) produce the same `new_pc` for the same base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_req | input | 15 | Fault request, one bit per class |
| cur_pc | input | AW | PC of the faulting instruction |
| handler_base | input | AW | Handler base address |
| restart_mask | input | 15 | Per-class force-save flag |
| skip_mask | input | 15 | Per-class skip (trap) flag |
| cnt_sel | input | 4 | Event counter select |
| redirect | output | 1 | Redirect strobe |
| new_pc | output | AW | Handler entry address |
| next_pc | output | AW | Address after the entry |
| exc_we | output | 1 | Exception-return register write enable |
| exc_addr | output | AW | Value for the exception-return register |
| cnt_value | output | CNT_W | Selected event counter |

## Verification
The hardest case to reach is a request that is still present while the strobe is high. Only a request held across two consecutive cycles shows that the second cycle is dropped and not counted. The scoreboard receives exactly one expected item for such a hold, so any extra redirect arrives with an empty queue and is reported. Counter saturation needs many accepted requests to one class, so the stimulus fires the interrupt class more times than the counter can hold, then reads every counter through the select.

// File: rtl/tvd_pkg.sv
package tvd_pkg;

    localparam int NUM_CLS    = 15;
    localparam int CLS_W      = 4;
    localparam int VEC_W      = 16;
    localparam int INSN_BYTES = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_RESET    = 4'd0,
        CLS_MCHK     = 4'd1,
        CLS_IACV     = 4'd2,
        CLS_IMISS    = 4'd3,
        CLS_OPDEC    = 4'd4,
        CLS_FPDIS    = 4'd5,
        CLS_PRIV     = 4'd6,
        CLS_ARITH    = 4'd7,
        CLS_OVF      = 4'd8,
        CLS_UNALIGN  = 4'd9,
        CLS_DMISS1   = 4'd10,
        CLS_DMISS2   = 4'd11,
        CLS_DPAGE    = 4'd12,
        CLS_DACV     = 4'd13,
        CLS_INTR     = 4'd14
    } trap_cls_e;

    typedef struct packed {
        logic      hit;
        trap_cls_e cls;
    } pick_t;

    function automatic logic [VEC_W-1:0] vector_of(trap_cls_e c);
        case (c)
            CLS_RESET:   return 16'h0001;
            CLS_MCHK:    return 16'h0401;
            CLS_IACV:    return 16'h0081;
            CLS_IMISS:   return 16'h0181;
            CLS_OPDEC:   return 16'h0481;
            CLS_FPDIS:   return 16'h0581;
            CLS_PRIV:    return 16'h2001;
            CLS_ARITH,
            CLS_OVF:     return 16'h0501;
            CLS_UNALIGN: return 16'h0301;
            CLS_DMISS1:  return 16'h0201;
            CLS_DMISS2:  return 16'h0281;
            CLS_DPAGE,
            CLS_DACV:    return 16'h0381;
            CLS_INTR:    return 16'h0101;
            default:     return 16'h0001;
        endcase
    endfunction

endpackage

// File: rtl/tvd_prio_sel.sv
module tvd_prio_sel
    import tvd_pkg::*;
(
    input  logic [NUM_CLS-1:0] req,
    output pick_t              pick
);
    always_comb begin
        pick.hit = 1'b0;
        pick.cls = CLS_RESET;
        for (int i = NUM_CLS - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.hit = 1'b1;
                pick.cls = trap_cls_e'(CLS_W'(i));
            end
        end
    end
endmodule

// File: rtl/tvd_addr_gen.sv
module tvd_addr_gen
    import tvd_pkg::*;
#(
    parameter int AW = 32
) (
    input  trap_cls_e     cls,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] handler_base,
    input  logic          restart,
    input  logic          skip,
    output logic [AW-1:0] tgt_pc,
    output logic [AW-1:0] tgt_next,
    output logic          save_en,
    output logic [AW-1:0] save_addr
);
    logic [AW-1:0] base_even;

    always_comb begin
        base_even = {handler_base[AW-1:1], 1'b0};
        tgt_pc    = base_even + AW'(vector_of(cls));
        tgt_next  = tgt_pc + AW'(INSN_BYTES);
        save_en   = restart || (cur_pc[1:0] == 2'b00);
        save_addr = skip ? (cur_pc + AW'(INSN_BYTES)) : cur_pc;
    end
endmodule

// File: rtl/tvd_evt_cnt.sv
module tvd_evt_cnt
    import tvd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  trap_cls_e        inc_cls,
    input  logic [CLS_W-1:0] sel,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt [NUM_CLS];

    for (genvar i = 0; i < NUM_CLS; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[i] <= '0;
            end else if (inc_en && (inc_cls == trap_cls_e'(CLS_W'(i)))
                         && (cnt[i] != CNT_MAX)) begin
                cnt[i] <= cnt[i] + 1'b1;
            end
        end
    end

    always_comb begin
        value = '0;
        for (int i = 0; i < NUM_CLS; i++) begin
            if (sel == CLS_W'(i)) value = cnt[i];
        end
    end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
    import tvd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CLS-1:0] fault_req,
    input  logic [AW-1:0]      cur_pc,
    input  logic [AW-1:0]      handler_base,
    input  logic [NUM_CLS-1:0] restart_mask,
    input  logic [NUM_CLS-1:0] skip_mask,
    input  logic [CLS_W-1:0]   cnt_sel,
    output logic               redirect,
    output logic [AW-1:0]      new_pc,
    output logic [AW-1:0]      next_pc,
    output logic               exc_we,
    output logic [AW-1:0]      exc_addr,
    output logic [CNT_W-1:0]   cnt_value
);
    pick_t         pick;
    logic          accept;
    logic [AW-1:0] tgt_pc, tgt_next, save_addr;
    logic          save_en;

    tvd_prio_sel u_prio (
        .req  (fault_req),
        .pick (pick)
    );

    // A redirect in flight flushes the pipe, so requests in that cycle are dropped.
    assign accept = pick.hit && !redirect;

    tvd_addr_gen #(.AW(AW)) u_addr (
        .cls          (pick.cls),
        .cur_pc       (cur_pc),
        .handler_base (handler_base),
        .restart      (restart_mask[pick.cls]),
        .skip         (skip_mask[pick.cls]),
        .tgt_pc       (tgt_pc),
        .tgt_next     (tgt_next),
        .save_en      (save_en),
        .save_addr    (save_addr)
    );

    tvd_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc_en  (accept),
        .inc_cls (pick.cls),
        .sel     (cnt_sel),
        .value   (cnt_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect <= 1'b0;
            exc_we   <= 1'b0;
            new_pc   <= '0;
            next_pc  <= '0;
            exc_addr <= '0;
        end else begin
            redirect <= accept;
            exc_we   <= accept && save_en;
            if (accept) begin
                new_pc   <= tgt_pc;
                next_pc  <= tgt_next;
                exc_addr <= save_addr;
            end
        end
    end
endmodule

// File: rtl/tvd_checker.sv
module tvd_checker
    import tvd_pkg::*;
#(
    parameter int AW = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_CLS-1:0] fault_req,
    input logic [AW-1:0]      cur_pc,
    input logic               redirect,
    input logic               exc_we,
    input logic [AW-1:0]      new_pc,
    input logic [AW-1:0]      next_pc
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!redirect && !exc_we)); // R1
    AST_NEXT_STEP: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (next_pc == new_pc + AW'(INSN_BYTES))); // R4
    AST_WE_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        exc_we |-> redirect); // R5
    AST_ALIGNED_SAVES: assert property (@(posedge clk) disable iff (rst)
        ((|fault_req) && !redirect && (cur_pc[1:0] == 2'b00)) |=> exc_we); // R5
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !redirect); // R7
    AST_REQ_REDIRECTS: assert property (@(posedge clk) disable iff (rst)
        ((|fault_req) && !redirect) |=> redirect); // R7
    AST_ODD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        redirect |-> new_pc[0]); // R8
endmodule

bind trap_dispatch tvd_checker #(.AW(AW)) u_tvd_checker (
    .clk       (clk),
    .rst       (rst),
    .fault_req (fault_req),
    .cur_pc    (cur_pc),
    .redirect  (redirect),
    .exc_we    (exc_we),
    .new_pc    (new_pc),
    .next_pc   (next_pc)
);

// File: tb/test_trap_dispatch.sv
`timescale 1ns/1ps
module test_trap_dispatch;
    localparam int AW = 32;
    localparam int CW = 4;
    localparam int NC = 15;

    logic          clk = 1'b0;
    logic          rst;
    logic [NC-1:0] fault_req, restart_mask, skip_mask;
    logic [AW-1:0] cur_pc, handler_base;
    logic [3:0]    cnt_sel;
    logic          redirect, exc_we;
    logic [AW-1:0] new_pc, next_pc, exc_addr;
    logic [CW-1:0] cnt_value;

    int checks = 0;
    int failures = 0;
    int cnt_model [NC];
    bit done = 1'b0;

    typedef struct {
        logic [AW-1:0] npc;
        logic [AW-1:0] nnpc;
        logic          we;
        logic [AW-1:0] addr;
    } exp_t;
    exp_t  exp_q [$];
    string tag_q [$];

    always #2 clk = ~clk;

    trap_dispatch #(.AW(AW), .CNT_W(CW)) i_trap_dispatch (
        .clk(clk), .rst(rst), .fault_req(fault_req), .cur_pc(cur_pc),
        .handler_base(handler_base), .restart_mask(restart_mask),
        .skip_mask(skip_mask), .cnt_sel(cnt_sel), .redirect(redirect),
        .new_pc(new_pc), .next_pc(next_pc), .exc_we(exc_we),
        .exc_addr(exc_addr), .cnt_value(cnt_value)
    );

    function automatic logic [15:0] ref_vec(int c);
        case (c)
            0: return 16'h0001;  1: return 16'h0401;  2: return 16'h0081;
            3: return 16'h0181;  4: return 16'h0481;  5: return 16'h0581;
            6: return 16'h2001;  7: return 16'h0501;  8: return 16'h0501;
            9: return 16'h0301; 10: return 16'h0201; 11: return 16'h0281;
           12: return 16'h0381; 13: return 16'h0381; 14: return 16'h0101;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Driver: presents one request for one cycle and queues what must come out.
    task automatic fire(input string tag, input logic [NC-1:0] req, input logic [AW-1:0] pc,
                        input logic [AW-1:0] base, input logic [NC-1:0] rmask,
                        input logic [NC-1:0] smask);
        exp_t e;
        int w;
        @(negedge clk);
        fault_req = req; cur_pc = pc; handler_base = base;
        restart_mask = rmask; skip_mask = smask;
        w = -1;
        for (int i = NC - 1; i >= 0; i--) if (req[i]) w = i;
        e.npc  = {base[AW-1:1], 1'b0} + AW'(ref_vec(w));
        e.nnpc = e.npc + 4;
        e.we   = rmask[w] || (pc[1:0] == 2'b00);
        e.addr = smask[w] ? pc + 4 : pc;
        if (cnt_model[w] < 15) cnt_model[w]++;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        fault_req = '0;
    endtask

    // Monitor: pops one expected item per observed redirect.
    always @(negedge clk) begin
        if (!rst && redirect) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R7 unexpected redirect actual=1 expected=0");
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " new_pc"}, new_pc, e.npc);
                check({t, " R4 next_pc"}, next_pc, e.nnpc);
                check({t, " R5 exc_we"}, AW'(exc_we), AW'(e.we));
                if (e.we) check({t, " R6 exc_addr"}, exc_addr, e.addr);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) cnt_model[i] = 0;
        rst = 1'b1; fault_req = '0; cur_pc = '0; handler_base = '0;
        restart_mask = '0; skip_mask = '0; cnt_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 redirect", AW'(redirect), 0);
        check("R1 exc_we", AW'(exc_we), 0);
        for (int i = 0; i < NC; i++) begin
            cnt_sel = 4'(i); #0.5;
            check("R1 counter", AW'(cnt_value), 0);
        end

        // R2 each class alone, aligned PC
        for (int i = 0; i < NC; i++)
            fire("R2 class", NC'(1) << i, 32'h0000_4000 + 32'(i * 16), 32'h0001_0000, '0, '0);

        // R10 shared offsets under a different base
        fire("R10 arith", NC'(1) << 7, 32'h100, 32'h0080_0000, '0, '0);
        fire("R10 ovf",   NC'(1) << 8, 32'h100, 32'h0080_0000, '0, '0);
        fire("R10 dpage", NC'(1) << 12, 32'h200, 32'h0080_0000, '0, '0);
        fire("R10 dacv",  NC'(1) << 13, 32'h200, 32'h0080_0000, '0, '0);

        // R3 priority
        fire("R3 pair", (NC'(1) << 3) | (NC'(1) << 9), 32'h300, 32'h0002_0000, '0, '0);
        fire("R3 all", '1, 32'h304, 32'h0002_0000, '0, '0);
        fire("R3 high pair", (NC'(1) << 13) | (NC'(1) << 14), 32'h308, 32'h0002_0000, '0, '0);

        // R5 misaligned PC without and with restart flag
        fire("R5 misaligned", NC'(1) << 9, 32'h0000_5002, 32'h0003_0000, '0, '0);
        fire("R5 forced", NC'(1) << 9, 32'h0000_5003, 32'h0003_0000, NC'(1) << 9, '0);
        fire("R5 other flag", NC'(1) << 9, 32'h0000_5001, 32'h0003_0000, NC'(1) << 4, '0);

        // R6 skip past faulting instruction
        fire("R6 skip", NC'(1) << 7, 32'h0000_6000, 32'h0003_0000, '0, NC'(1) << 7);
        fire("R6 skip forced", NC'(1) << 8, 32'h0000_6002, 32'h0003_0000, NC'(1) << 8, NC'(1) << 8);
        fire("R6 other skip", NC'(1) << 6, 32'h0000_6004, 32'h0003_0000, '0, NC'(1) << 7);

        // R8 base bit 0 ignored
        fire("R8 odd base", NC'(1) << 14, 32'h700, 32'h0004_0001, '0, '0);

        // R7 request held across the redirect cycle
        @(negedge clk);
        fault_req = NC'(1) << 10; cur_pc = 32'h800; handler_base = 32'h0005_0000;
        restart_mask = '0; skip_mask = '0;
        exp_q.push_back('{32'h0005_0201, 32'h0005_0205, 1'b1, 32'h800});
        tag_q.push_back("R7 held");
        cnt_model[10]++;
        @(negedge clk);
        check("R7 strobe high", AW'(redirect), 1);
        @(negedge clk);
        fault_req = '0;
        check("R7 held request ignored", AW'(redirect), 0);
        @(negedge clk);
        check("R7 no late redirect", AW'(redirect), 0);

        // R9 saturate the interrupt counter
        for (int k = 0; k < 20; k++)
            fire("R9 sat", NC'(1) << 14, 32'h900, 32'h0006_0000, '0, '0);
        @(negedge clk);
        for (int i = 0; i < NC; i++) begin
            cnt_sel = 4'(i); #0.5;
            check($sformatf("R9 counter %0d", i), AW'(cnt_value), AW'(cnt_model[i]));
        end
        cnt_sel = 4'd15; #0.5;
        check("R9 out of range select", AW'(cnt_value), 0);

        repeat (3) @(negedge clk);
        check("R7 scoreboard drained", AW'(exp_q.size()), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule